// File: doc/BRIEF.md
# Fetch Queue with Static Branch Prediction

This block sits between an instruction fetch port and a single-issue decode stage. It holds up to three instruction words: a decode slot, an inner prefetch slot next to it, and an outer prefetch slot behind that. The fetch port can deliver up to two words per cycle. Words always leave through the decode slot in the order they arrived. When the queue is empty, the first arriving word is written straight into the decode slot.

Every cycle the block looks at the branch in the decode slot and the branch in the inner prefetch slot, using a simplified encoding. It predicts each one statically from the sign of its displacement, from whether it tests a condition, and from a software hint bit. When a prediction sends fetch somewhere new, the block raises a redirect with the new fetch address in the same cycle. It then drops every queued or arriving word that is younger than the redirecting branch.

A decode-slot redirect takes precedence, and it cancels any prediction for the inner slot. A mispredict input from the execute stage empties the whole queue and overrides both redirects.

The queue occupancy is a four-state machine:
- Q_EMPTY holds no word; Q_ONE holds the decode slot only; Q_TWO holds the decode and inner slots; Q_FULL holds all three slots.
- The fill transition moves up by the number of accepted words.
- The drain transition moves down by one when decode takes its word.
- The hold transition keeps the state while decode stalls and nothing arrives.
- The flush transition drops to the number of entries that survive a redirect: Q_EMPTY on a mispredict, and at most Q_ONE or Q_TWO on a decode or inner redirect, less one if decode takes its word in the same cycle.

Top module: `fetch_queue`

## Requirements
- R1: After reset, and whenever reset is asserted, the queue is empty: `dec_valid` is 0, `redir_valid` is 0 and `in_ready` is 1.
- R2: Words reach `dec_word` in the order they arrived. A word accepted into an empty queue is presented on `dec_word`/`dec_pc` in the next cycle. The second word of a pair takes address `in_pc`+4.
- R3: `in_cnt` gives the number of offered words: 0, 1, or 2 (codes 2 and 3 both mean two). `in_ready` is 1 exactly when, after this cycle's hand-off to decode, at most one entry remains. In state Q_FULL, `in_ready` is 0. Offered words are accepted only while `in_ready` is 1.
- R4: While `dec_stall` is 1 and no mispredict occurs, the decode slot keeps its word and address, and `dec_valid` stays 1. A word is handed off on each cycle where `dec_valid` is 1 and `dec_stall` is 0.
- R5: Branch encoding and prediction:
  - Bit 31 marks a branch.
  - Bit 30 marks a branch that tests a condition or count.
  - Bit 29 is the hint.
  - Bits 15:0 are a signed byte displacement from the branch's own address.
  - The default prediction is taken when bit 30 is 0 or the displacement is negative. The hint bit inverts the default.
  - A branch predicted not taken raises no redirect.
- R6: The decode-slot branch redirects when it is predicted taken and has not yet redirected. In that cycle `redir_valid` is 1 and `redir_pc` is its address plus displacement. Both prefetch slots and the words offered in that cycle are dropped, and the inner-slot branch is ignored.
- R7: The inner-slot branch redirects when the decode slot does not redirect and the inner branch is predicted taken. `redir_pc` is the inner target. The outer slot and the offered words are dropped, and the inner branch stays queued and later reaches decode.
- R8: A branch raises at most one redirect, even while it is stalled in decode or after it moves from the inner slot into decode.
- R9: When `ex_mispredict` is 1, `redir_valid` is 1 and `redir_pc` equals `ex_target`, overriding R6 and R7. All entries, including decode, are dropped; `dec_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_cnt | input | 2 | Number of words offered this cycle |
| in_word0 | input | 32 | Older offered word |
| in_word1 | input | 32 | Younger offered word |
| in_pc | input | 32 | Byte address of `in_word0` |
| in_ready | output | 1 | Queue can take two words this cycle |
| dec_valid | output | 1 | Decode slot holds a word |
| dec_word | output | 32 | Word in the decode slot |
| dec_pc | output | 32 | Address of the decode word |
| dec_stall | input | 1 | Decode cannot take its word |
| redir_valid | output | 1 | Fetch must restart at `redir_pc` |
| redir_pc | output | 32 | New fetch address |
| ex_mispredict | input | 1 | Execute stage found a wrong path |
| ex_target | input | 32 | Corrected fetch address |

## Verification
The assertions watch properties that hold on every cycle:
- `in_ready` is low in Q_FULL.
- The decode word holds under a stall.
- The decode slot empties after a mispredict.
- The occupancy collapses after a decode-slot redirect.
- Each branch redirects only once.
- The inner word advances into decode in order.

Prediction values need whole scenarios that only the bench's sequences show:
- the hint inversion;
- backward against forward displacements;
- unconditional branches;
- two branches in flight at once, where the decode-slot branch must win with its own target;
- the redirect address chosen when a mispredict coincides with a taken decode branch.

// File: rtl/fq_pkg.sv
package fq_pkg;

    localparam int FQ_SLOTS  = 3;
    localparam int FQ_MAX_IN = 2;
    localparam int FQ_LINE   = FQ_SLOTS + FQ_MAX_IN;
    localparam int FQ_CNT_W  = $clog2(FQ_LINE + 1);

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_ONE   = 2'd1,
        Q_TWO   = 2'd2,
        Q_FULL  = 2'd3
    } q_state_e;

endpackage

// File: rtl/fq_predict.sv
module fq_predict #(
    parameter int AW     = 32,
    parameter int DISP_W = 16
) (
    input  logic              valid,
    input  logic              br_flag,
    input  logic              cond_flag,
    input  logic              hint_flag,
    input  logic [DISP_W-1:0] disp,
    input  logic [AW-1:0]     pc,
    output logic              taken,
    output logic [AW-1:0]     target
);

    localparam int EXT_W = AW - DISP_W;

    logic backward;
    logic dflt_taken;

    always_comb begin
        backward   = disp[DISP_W-1];
        dflt_taken = ~cond_flag | backward;
        taken      = valid & br_flag & (dflt_taken ^ hint_flag);
        target     = pc + {{EXT_W{disp[DISP_W-1]}}, disp};
    end

endmodule

// File: rtl/fq_slots.sv
module fq_slots
    import fq_pkg::*;
#(
    parameter int IW         = 32,
    parameter int AW         = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FQ_CNT_W-1:0] occ,
    input  logic                pop,
    input  logic [1:0]          take,
    input  logic                mark_dec,
    input  logic                mark_inner,
    input  logic [IW-1:0]       in_word0,
    input  logic [IW-1:0]       in_word1,
    input  logic [AW-1:0]       in_pc,
    output logic [IW-1:0]       dec_word,
    output logic [AW-1:0]       dec_pc,
    output logic                dec_done,
    output logic [IW-1:0]       inner_word,
    output logic [AW-1:0]       inner_pc,
    output logic                inner_done
);

    localparam int NS = FQ_SLOTS;
    localparam int NL = FQ_LINE;

    logic [NS-1:0][IW-1:0] sw_q, sw_d;
    logic [NS-1:0][AW-1:0] sp_q, sp_d;
    logic [NS-1:0]         sd_q, sd_d;

    logic [NL-1:0][IW-1:0] lw;
    logic [NL-1:0][AW-1:0] lp;
    logic [NL-1:0]         ld;

    // Line of held entries followed by the accepted words, oldest first
    always_comb begin
        lw = '0;
        lp = '0;
        ld = '0;
        for (int k = 0; k < NS; k++) begin
            if (k < int'(occ)) begin
                lw[k] = sw_q[k];
                lp[k] = sp_q[k];
                ld[k] = sd_q[k];
            end
        end
        if (take != 2'd0) begin
            lw[occ] = in_word0;
            lp[occ] = in_pc;
        end
        if (take == 2'd2) begin
            lw[occ + 3'd1] = in_word1;
            lp[occ + 3'd1] = in_pc + AW'(INSN_BYTES);
        end
        ld[0] = ld[0] | mark_dec;
        ld[1] = ld[1] | mark_inner;
    end

    // Advance by one position when decode hands its word off
    always_comb begin
        for (int i = 0; i < NS; i++) begin
            sw_d[i] = lw[i + int'(pop)];
            sp_d[i] = lp[i + int'(pop)];
            sd_d[i] = ld[i + int'(pop)];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q <= '0;
            sp_q <= '0;
            sd_q <= '0;
        end else begin
            sw_q <= sw_d;
            sp_q <= sp_d;
            sd_q <= sd_d;
        end
    end

    assign dec_word   = sw_q[0];
    assign dec_pc     = sp_q[0];
    assign dec_done   = sd_q[0];
    assign inner_word = sw_q[1];
    assign inner_pc   = sp_q[1];
    assign inner_done = sd_q[1];

    // R8: a branch that redirected from decode is remembered while it waits
    p_dec_mark_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_dec && !pop) |=> dec_done);

    // R8: an inner branch that redirected keeps its mark into decode
    p_inner_mark_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_inner && pop) |=> dec_done);

endmodule

// File: rtl/fetch_queue.sv
module fetch_queue
    import fq_pkg::*;
#(
    parameter int IW         = 32,
    parameter int AW         = 32,
    parameter int DISP_W     = 16,
    parameter int BR_BIT     = 31,
    parameter int COND_BIT   = 30,
    parameter int HINT_BIT   = 29,
    parameter int INSN_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    in_cnt,
    input  logic [IW-1:0] in_word0,
    input  logic [IW-1:0] in_word1,
    input  logic [AW-1:0] in_pc,
    output logic          in_ready,
    output logic          dec_valid,
    output logic [IW-1:0] dec_word,
    output logic [AW-1:0] dec_pc,
    input  logic          dec_stall,
    output logic          redir_valid,
    output logic [AW-1:0] redir_pc,
    input  logic          ex_mispredict,
    input  logic [AW-1:0] ex_target
);

    localparam int NPRED = 2;

    q_state_e state, state_next;

    logic [FQ_CNT_W-1:0] occ, remain, total, keep_lim, kept, next_occ;
    logic [1:0]          take;
    logic                pop;
    logic                dec_redir, inner_redir;

    logic [IW-1:0]       inner_word;
    logic [AW-1:0]       inner_pc;
    logic                dec_done, inner_done;

    logic [NPRED-1:0][IW-1:0] pw;
    logic [NPRED-1:0][AW-1:0] ppc;
    logic [NPRED-1:0][AW-1:0] p_target;
    logic [NPRED-1:0]         p_taken;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= Q_EMPTY;
        end else begin
            state <= state_next;
        end
    end

    // Outputs and decisions derived from the current state
    always_comb begin
        unique case (state)
            Q_EMPTY: occ = 3'd0;
            Q_ONE:   occ = 3'd1;
            Q_TWO:   occ = 3'd2;
            Q_FULL:  occ = 3'd3;
        endcase

        dec_valid = (occ != 3'd0);
        pop       = dec_valid & ~dec_stall;
        remain    = occ - {2'b00, pop};
        in_ready  = (remain <= 3'd1);

        dec_redir   = ~ex_mispredict & p_taken[0] & ~dec_done;
        inner_redir = ~ex_mispredict & ~dec_redir & p_taken[1] & ~inner_done;
        redir_valid = ex_mispredict | dec_redir | inner_redir;

        if (ex_mispredict) begin
            redir_pc = ex_target;
        end else if (dec_redir) begin
            redir_pc = p_target[0];
        end else begin
            redir_pc = p_target[1];
        end

        if (in_ready && !redir_valid) begin
            take = in_cnt[1] ? 2'd2 : {1'b0, in_cnt[0]};
        end else begin
            take = 2'd0;
        end

        total = occ + {1'b0, take};
        if (ex_mispredict) begin
            keep_lim = 3'd0;
        end else if (dec_redir) begin
            keep_lim = 3'd1;
        end else if (inner_redir) begin
            keep_lim = 3'd2;
        end else begin
            keep_lim = 3'(FQ_LINE);
        end
        kept     = (total < keep_lim) ? total : keep_lim;
        next_occ = ex_mispredict ? 3'd0 : (kept - {2'b00, pop});
    end

    // Fill, drain, hold and flush all land through the surviving count
    always_comb begin
        unique case (next_occ)
            3'd0:    state_next = Q_EMPTY;
            3'd1:    state_next = Q_ONE;
            3'd2:    state_next = Q_TWO;
            default: state_next = Q_FULL;
        endcase
    end

    fq_slots #(
        .IW         (IW),
        .AW         (AW),
        .INSN_BYTES (INSN_BYTES)
    ) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .occ        (occ),
        .pop        (pop),
        .take       (take),
        .mark_dec   (dec_redir),
        .mark_inner (inner_redir),
        .in_word0   (in_word0),
        .in_word1   (in_word1),
        .in_pc      (in_pc),
        .dec_word   (dec_word),
        .dec_pc     (dec_pc),
        .dec_done   (dec_done),
        .inner_word (inner_word),
        .inner_pc   (inner_pc),
        .inner_done (inner_done)
    );

    assign pw[0]  = dec_word;
    assign pw[1]  = inner_word;
    assign ppc[0] = dec_pc;
    assign ppc[1] = inner_pc;

    for (genvar g = 0; g < NPRED; g++) begin : g_pred
        fq_predict #(
            .AW     (AW),
            .DISP_W (DISP_W)
        ) u_pred (
            .valid     (occ > 3'(g)),
            .br_flag   (pw[g][BR_BIT]),
            .cond_flag (pw[g][COND_BIT]),
            .hint_flag (pw[g][HINT_BIT]),
            .disp      (pw[g][DISP_W-1:0]),
            .pc        (ppc[g]),
            .taken     (p_taken[g]),
            .target    (p_target[g])
        );
    end

    // R3: a full queue never advertises room
    p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_FULL) |-> !in_ready);

    // R4: a stalled decode word stays put
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_stall && !ex_mispredict) |=>
            (dec_valid && $stable(dec_word) && $stable(dec_pc)));

    // R9: a mispredict leaves nothing in decode
    p_misp_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ex_mispredict |=> !dec_valid);

    // R6: a decode redirect leaves at most the branch itself
    p_dec_redir_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_redir |=> (state == Q_EMPTY || state == Q_ONE));

    // R8: a stalled redirecting decode branch does not redirect again
    p_single_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_redir && dec_stall) |=> (!redir_valid || ex_mispredict));

    // R2: the inner word is the next one to reach decode
    p_in_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && occ >= 3'd2 && !ex_mispredict && !dec_redir) |=>
            (dec_word == $past(inner_word)));

endmodule

// File: tb/tb_fetch_queue.sv
module tb_fetch_queue;

    localparam int CLK_NS = 20;
    localparam int NVEC   = 20;

    typedef struct packed {
        logic [1:0]  cnt;
        logic [31:0] w0;
        logic [31:0] w1;
        logic [31:0] pc;
        logic        stall;
        logic        misp;
        logic [31:0] mtgt;
        logic        e_ready;
        logic        e_rv;
        logic [31:0] e_rpc;
        logic        e_dv;
        logic [31:0] e_dw;
        logic [7:0]  req;
    } vec_t;

    // Branch words: C000_0010 cond +16 (not taken), C000_FFF0 cond -16 (taken),
    // 8000_0020 unconditional +32 (taken), A000_0020 unconditional hinted (not taken),
    // E000_0040 cond +64 hinted (taken). Plain words have bit 31 clear.
    localparam vec_t VECS [NVEC] = '{
        '{2'd2, 32'h11, 32'h12, 32'h100, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0, 8'd2},          // R2 empty fill
        '{2'd2, 32'h13, 32'hC000_0010, 32'h108, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b1, 32'h11, 8'd3},  // R3 two words
        '{2'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h12, 8'd3},             // R3 full
        '{2'd2, 32'hC000_FFF0, 32'h14, 32'h110, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b1, 32'h13, 8'd5},  // R5 fwd cond inner
        '{2'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 32'h100, 1'b1, 32'hC000_0010, 8'd7},    // R7 inner backward
        '{2'd2, 32'h21, 32'h22, 32'h100, 1'b1, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b1, 32'hC000_FFF0, 8'd8},  // R8 no repeat
        '{2'd0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'hC000_FFF0, 8'd4},      // R4 stall hold
        '{2'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 32'hC000_FFF0, 8'd8},
        '{2'd2, 32'h8000_0020, 32'h15, 32'h108, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b1, 32'h21, 8'd2},
        '{2'd0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 32'h128, 1'b1, 32'h22, 8'd7},           // R7 unconditional
        '{2'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b1, 32'h22, 8'd8},
        '{2'd2, 32'h31, 32'hA000_0020, 32'h128, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b1, 32'h8000_0020, 8'd8},
        '{2'd2, 32'hE000_0040, 32'h32, 32'h130, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b1, 32'h31, 8'd5},  // R5 hint on unc
        '{2'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 32'h170, 1'b1, 32'hA000_0020, 8'd5},    // R5 hint on fwd
        '{2'd2, 32'hC000_FFF0, 32'h8000_0020, 32'h170, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b1, 32'hE000_0040, 8'd8},
        '{2'd2, 32'h41, 32'h42, 32'h178, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 32'h160, 1'b1, 32'hC000_FFF0, 8'd6}, // R6 both taken
        '{2'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0, 8'd6},              // R6 all dropped
        '{2'd2, 32'h8000_0020, 32'h51, 32'h160, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0, 8'd2},
        '{2'd0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b1, 32'h200, 1'b0, 1'b1, 32'h200, 1'b1, 32'h8000_0020, 8'd9},  // R9 priority
        '{2'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0, 8'd9}               // R9 emptied
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  in_cnt = '0;
    logic [31:0] in_word0 = '0, in_word1 = '0, in_pc = '0;
    logic        in_ready, dec_valid, redir_valid;
    logic [31:0] dec_word, dec_pc, redir_pc;
    logic        dec_stall = 1'b0, ex_mispredict = 1'b0;
    logic [31:0] ex_target = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    fetch_queue dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_cnt        (in_cnt),
        .in_word0      (in_word0),
        .in_word1      (in_word1),
        .in_pc         (in_pc),
        .in_ready      (in_ready),
        .dec_valid     (dec_valid),
        .dec_word      (dec_word),
        .dec_pc        (dec_pc),
        .dec_stall     (dec_stall),
        .redir_valid   (redir_valid),
        .redir_pc      (redir_pc),
        .ex_mispredict (ex_mispredict),
        .ex_target     (ex_target)
    );

    task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_cnt = '0; in_word0 = '0; in_word1 = '0; in_pc = '0;
        dec_stall = 1'b0; ex_mispredict = 1'b0; ex_target = '0;
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: empty after reset
        chk(1, "dec_valid after reset", {31'd0, dec_valid}, 32'd0);
        chk(1, "redir_valid after reset", {31'd0, redir_valid}, 32'd0);
        chk(1, "in_ready after reset", {31'd0, in_ready}, 32'd1);

        // Vector walk: inputs driven after a falling edge, outputs seen before the rising one
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            in_cnt = VECS[v].cnt; in_word0 = VECS[v].w0; in_word1 = VECS[v].w1;
            in_pc = VECS[v].pc; dec_stall = VECS[v].stall;
            ex_mispredict = VECS[v].misp; ex_target = VECS[v].mtgt;
            #2;
            chk(int'(VECS[v].req), $sformatf("vec %0d in_ready", v), {31'd0, in_ready}, {31'd0, VECS[v].e_ready});
            chk(int'(VECS[v].req), $sformatf("vec %0d redir_valid", v), {31'd0, redir_valid}, {31'd0, VECS[v].e_rv});
            if (VECS[v].e_rv)
                chk(int'(VECS[v].req), $sformatf("vec %0d redir_pc", v), redir_pc, VECS[v].e_rpc);
            chk(int'(VECS[v].req), $sformatf("vec %0d dec_valid", v), {31'd0, dec_valid}, {31'd0, VECS[v].e_dv});
            if (VECS[v].e_dv)
                chk(int'(VECS[v].req), $sformatf("vec %0d dec_word", v), dec_word, VECS[v].e_dw);
        end

        // R2: single word into an empty queue lands in decode next cycle with its address
        @(negedge clk);
        idle_inputs();
        in_cnt = 2'd1; in_word0 = 32'h61; in_pc = 32'h300;
        @(negedge clk);
        idle_inputs();
        dec_stall = 1'b1;
        #2;
        chk(2, "bypass dec_word", dec_word, 32'h61);
        chk(2, "bypass dec_pc", dec_pc, 32'h300);

        // R2: second word of a pair takes address +4
        @(negedge clk);
        dec_stall = 1'b0;
        @(negedge clk);
        idle_inputs();
        in_cnt = 2'd2; in_word0 = 32'h71; in_word1 = 32'h72; in_pc = 32'h400;
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        #2;
        chk(2, "pair second dec_word", dec_word, 32'h72);
        chk(2, "pair second dec_pc", dec_pc, 32'h404);

        // R1: reset while holding words empties the queue
        @(negedge clk);
        in_cnt = 2'd2; in_word0 = 32'h81; in_word1 = 32'h82; in_pc = 32'h500;
        @(negedge clk);
        idle_inputs();
        dec_stall = 1'b1;
        rst_n = 1'b0;
        #2;
        chk(1, "dec_valid in reset", {31'd0, dec_valid}, 32'd0);
        chk(1, "in_ready in reset", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        idle_inputs();
        @(negedge clk);
        #2;
        chk(1, "dec_valid after reset release", {31'd0, dec_valid}, 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_NS * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule